// File: doc/BRIEF.md
# Linear Page Table Walker

This block turns 32-bit virtual addresses into physical addresses using a flat, single-level page table held in memory. It takes one translation request at a time with a write flag and a user-mode flag. The upper twenty bits of the address select an entry, which sits at the table base plus four bytes per page. The block reads that entry over a memory request port and checks it. If a status bit needs to change, it writes the entry back. It then returns the physical address or a fault code.

All three data paths use valid/ready handshakes. On the request side, `req_ready` is high only while the walker is idle, so a second request waits until the first response has been accepted. On the response side, the result stays stable until `rsp_ready` takes it. The memory request channel holds its address, write flag and data until `mem_req_ready` is seen. The read-data channel is accepted through `mem_rsp_ready`, which is high only while a fetched entry is awaited. Writes need no reply. The table base `pt_base` is a plain level input, sampled when a request is accepted.

Top module: `pt_walker`

## Requirements
- R1: Each translation reads its entry at `pt_base + 4 * vaddr[31:12]`, computed modulo 2^32, with `mem_req_we` low and the low two address bits zero.
- R2: On success `rsp_fault` is 0 and `rsp_paddr` is the entry's bits 31:12 followed by `vaddr[11:0]` unchanged. On any fault `rsp_paddr` is zero.
- R3: If entry bit 11 (valid) is clear, the fault code is 1. This takes priority over all other checks.
- R4: If the entry is valid but bit 0 (present) is clear, the fault code is 2. This takes priority over protection.
- R5: If the entry is valid and present, the fault code is 3 in two cases: a write to an entry with bit 1 (write allowed) clear, or a user access to an entry with bit 2 (user allowed) clear.
- R6: After a successful check, the entry is written back to the same address with bit 5 (accessed) set, and bit 6 (dirty) also set for a write. This write happens only if the value changes. A faulting translation never writes.
- R7: A translation makes exactly one memory read, then at most one write. Reset or an idle walker produces no memory request.
- R8: `req_ready` is low from the accepting edge until the response is accepted, so only one walk is outstanding.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` stay unchanged.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request and all its fields stay unchanged.
- R11: During and after reset, `req_ready` is high while `rsp_valid`, `mem_req_valid` and `mem_rsp_ready` are low. This holds even if reset arrives mid-walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| pt_base | input | 32 | Physical base address of the page table |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 ok, 1 invalid, 2 not present, 3 protection |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write-back, 0 entry read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaiting read data |
| mem_rsp_rdata | input | 32 | Fetched entry |

## Verification
On every cycle, the assertions check the handshake rules. These are: the response and the memory request stay stable under back-pressure, the request side is locked while busy, a faulting response has a zero address, and every write-back carries the accessed, valid and present bits. Only the bench scenarios can show the arithmetic and decision outcomes. These are: the entry address for a given base and page number, the physical address composed from the fetched frame, the fault priority order, whether a write-back was issued and what it carried, the count of reads per walk, and recovery from a reset in mid-walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_PRESENT  = 0;
  localparam int PTE_WRITABLE = 1;
  localparam int PTE_USER     = 2;
  localparam int PTE_ACCESSED = 5;
  localparam int PTE_DIRTY    = 6;
  localparam int PTE_VALID    = 11;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_CHECK,
    ST_WBACK,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int PTE_W  = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] va_in,
  input  logic [ADDR_W-1:0] va_held,
  input  logic [PTE_W-1:0]  entry,
  output logic [ADDR_W-1:0] entry_addr,
  output logic [PTE_W-1:0]  phys_addr
);
  localparam int VPN_W     = ADDR_W - PAGE_W;
  localparam int ENT_SHIFT = $clog2(PTE_W / 8);
  localparam int FRAME_W   = PTE_W - PAGE_W;

  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] scaled;

  always_comb begin
    vpn        = va_in[ADDR_W-1:PAGE_W];
    scaled     = ADDR_W'({vpn, {ENT_SHIFT{1'b0}}});
    entry_addr = base + scaled;
  end

  logic [FRAME_W-1:0] frame;
  always_comb begin
    frame     = entry[PTE_W-1:PAGE_W];
    phys_addr = {frame, va_held[PAGE_W-1:0]};
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output fault_e           fault,
  output logic [PTE_W-1:0] entry_upd,
  output logic             need_wb
);
  always_comb begin
    if (!entry[PTE_VALID]) begin
      fault = FLT_INVALID;
    end else if (!entry[PTE_PRESENT]) begin
      fault = FLT_ABSENT;
    end else if ((is_write && !entry[PTE_WRITABLE]) ||
                 (is_user && !entry[PTE_USER])) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end
  end

  always_comb begin
    entry_upd = entry;
    entry_upd[PTE_ACCESSED] = 1'b1;
    if (is_write) entry_upd[PTE_DIRTY] = 1'b1;
    need_wb = (fault == FLT_NONE) && (entry_upd != entry);
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] ent_addr_in,
  output logic [ADDR_W-1:0] va_q,
  output logic              wr_q,
  output logic              usr_q,
  output logic [PTE_W-1:0]  pte_q,
  input  fault_e            chk_fault,
  input  logic [PTE_W-1:0]  chk_upd,
  input  logic              chk_wb,
  input  logic [PTE_W-1:0]  chk_pa,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PTE_W-1:0]  rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [PTE_W-1:0]  mem_rsp_rdata
);
  walk_state_e       state, state_nx;
  logic [ADDR_W-1:0] ea_q;
  logic [PTE_W-1:0]  pa_q;
  fault_e            flt_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (req_valid)     state_nx = ST_FETCH;
      ST_FETCH: if (mem_req_ready) state_nx = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_nx = ST_CHECK;
      ST_CHECK: state_nx = chk_wb ? ST_WBACK : ST_RESP;
      ST_WBACK: if (mem_req_ready) state_nx = ST_RESP;
      ST_RESP:  if (rsp_ready)     state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      va_q  <= '0;
      wr_q  <= 1'b0;
      usr_q <= 1'b0;
      ea_q  <= '0;
      pte_q <= '0;
      pa_q  <= '0;
      flt_q <= FLT_NONE;
    end else begin
      state <= state_nx;
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= req_user;
          ea_q  <= ent_addr_in;
        end
        ST_WAIT: if (mem_rsp_valid) pte_q <= mem_rsp_rdata;
        ST_CHECK: begin
          flt_q <= chk_fault;
          pa_q  <= (chk_fault == FLT_NONE) ? chk_pa : '0;
          pte_q <= chk_upd;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == ST_IDLE);
    mem_req_valid = (state == ST_FETCH) || (state == ST_WBACK);
    mem_req_we    = (state == ST_WBACK);
    mem_req_addr  = ea_q;
    mem_req_wdata = (state == ST_WBACK) ? pte_q : '0;
    mem_rsp_ready = (state == ST_WAIT);
    rsp_valid     = (state == ST_RESP);
    rsp_paddr     = pa_q;
    rsp_fault     = flt_q;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int PTE_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] pt_base,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PTE_W-1:0]  rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [PTE_W-1:0]  mem_rsp_rdata
);
  logic [ADDR_W-1:0] ent_addr, va_q;
  logic              wr_q, usr_q;
  logic [PTE_W-1:0]  pte_q, pa, upd;
  fault_e            flt;
  logic              wb;

  ptw_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PTE_W(PTE_W)) u_addr (
    .base(pt_base), .va_in(req_vaddr), .va_held(va_q), .entry(pte_q),
    .entry_addr(ent_addr), .phys_addr(pa)
  );

  ptw_pte_eval #(.PTE_W(PTE_W)) u_eval (
    .entry(pte_q), .is_write(wr_q), .is_user(usr_q),
    .fault(flt), .entry_upd(upd), .need_wb(wb)
  );

  ptw_ctrl #(.ADDR_W(ADDR_W), .PTE_W(PTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .ent_addr_in(ent_addr),
    .va_q(va_q), .wr_q(wr_q), .usr_q(usr_q), .pte_q(pte_q),
    .chk_fault(flt), .chk_upd(upd), .chk_wb(wb), .chk_pa(pa),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PTE_W-1:0]  rsp_paddr,
  input logic [1:0]        rsp_fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [PTE_W-1:0]  mem_req_wdata,
  input logic              mem_rsp_ready
);
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  a_r8_lock_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r8_busy_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r2_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0);

  a_r6_wb_bits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[5] && mem_req_wdata[11] && mem_req_wdata[0]);

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .PTE_W(PTE_W)) u_chk (.*);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, pt_base = 32'h0040_0000;
  logic        rsp_ready = 1'b0, mem_req_ready = 1'b1;
  logic        req_ready, rsp_valid, mem_req_valid, mem_req_we, mem_rsp_ready;
  logic [31:0] rsp_paddr, mem_req_addr, mem_req_wdata;
  logic [1:0]  rsp_fault;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #2 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .pt_base(pt_base), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: serves cur_pte for any read, logs every request
  logic [31:0] cur_pte = '0;
  int          rd_count, wr_count;
  logic [31:0] rd_addr, wr_addr, wr_data;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
    end else begin
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_we) begin
          rd_count      <= rd_count + 1;
          rd_addr       <= mem_req_addr;
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= cur_pte;
        end else begin
          wr_count <= wr_count + 1;
          wr_addr  <= mem_req_addr;
          wr_data  <= mem_req_wdata;
        end
      end
    end
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // vector: vaddr, write, user, pte, fault, writeback
  localparam int NV = 11;
  localparam logic [68:0] VEC [NV] = '{
    {32'h0000_3ABC, 1'b0, 1'b1, 32'h1234_5807, 2'd0, 1'b1},
    {32'h0001_0010, 1'b1, 1'b1, 32'hABCD_E867, 2'd0, 1'b0},
    {32'hFFFF_F123, 1'b0, 1'b0, 32'h0004_2821, 2'd0, 1'b0},
    {32'h8000_0FFF, 1'b1, 1'b0, 32'h0004_2823, 2'd0, 1'b1},
    {32'h0000_5000, 1'b0, 1'b0, 32'h0004_2007, 2'd1, 1'b0},
    {32'h0000_6001, 1'b0, 1'b0, 32'h0004_2806, 2'd2, 1'b0},
    {32'h0000_7002, 1'b1, 1'b0, 32'h0004_2805, 2'd3, 1'b0},
    {32'h0000_8003, 1'b0, 1'b1, 32'h0004_2803, 2'd3, 1'b0},
    {32'h0000_9004, 1'b1, 1'b1, 32'h0000_0006, 2'd1, 1'b0},
    {32'h0000_A005, 1'b1, 1'b1, 32'h0004_2800, 2'd2, 1'b0},
    {32'h7654_3210, 1'b1, 1'b1, 32'hFFFF_F807, 2'd0, 1'b1}
  };

  task automatic translate(input logic [31:0] va, input bit wr, input bit usr,
                           input logic [31:0] pte, input logic [1:0] efl,
                           input bit ewb, input int hold, input int stall);
    int rd0, wr0, n;
    logic [31:0] ea, epa, ewd, a0, pa0;
    string ftag;
    ea   = pt_base + {va[31:12], 2'b00};
    epa  = (efl == 2'd0) ? {pte[31:12], va[11:0]} : 32'h0;
    ewd  = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    ftag = (efl == 2'd1) ? "R3" : (efl == 2'd2) ? "R4" : (efl == 2'd3) ? "R5" : "R2";
    rd0 = rd_count; wr0 = wr_count;
    @(negedge clk);
    mem_req_ready = (stall == 0);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; cur_pte = pte;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 busy after accept", {31'd0, req_ready}, 32'd0);
    if (stall > 0) begin
      a0 = mem_req_addr;
      for (int i = 0; i < stall; i++) begin
        chk(mem_req_valid && mem_req_addr == a0 && !mem_req_we, "R10 stalled request held",
            mem_req_addr, a0);
        @(negedge clk);
      end
      mem_req_ready = 1'b1;
    end
    n = 0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) chk(1'b0, "R8 ready during walk", 32'd1, 32'd0);
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, "R8 response arrives", {31'd0, rsp_valid}, 32'd1);
    chk(rd_count - rd0 == 1, "R7 one read", rd_count - rd0, 32'd1);
    chk(rd_addr == ea, "R1 entry address", rd_addr, ea);
    chk(rsp_fault == efl, {ftag, " fault code"}, {30'd0, rsp_fault}, {30'd0, efl});
    chk(rsp_paddr == epa, {ftag, " physical address"}, rsp_paddr, epa);
    if (ewb) begin
      chk(wr_count - wr0 == 1, "R6 write-back issued", wr_count - wr0, 32'd1);
      chk(wr_addr == ea, "R6 write-back address", wr_addr, ea);
      chk(wr_data == ewd, "R6 write-back data", wr_data, ewd);
    end else begin
      chk(wr_count - wr0 == 0, "R6 no write-back", wr_count - wr0, 32'd0);
    end
    pa0 = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0 && rsp_fault == efl, "R9 response held",
          rsp_paddr, pa0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8 idle after accept", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready, "R11 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk(!rsp_valid && !mem_req_valid && !mem_rsp_ready, "R11 reset outputs quiet",
        {29'd0, rsp_valid, mem_req_valid, mem_rsp_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && rd_count == 0 && wr_count == 0, "R7 idle no memory traffic",
        rd_count + wr_count, 32'd0);

    for (int v = 0; v < NV; v++) begin
      translate(VEC[v][68:37], VEC[v][36], VEC[v][35], VEC[v][34:3],
                VEC[v][2:1], VEC[v][0], 0, 0);
    end

    // back-pressure on response and memory stall
    translate(32'h0012_3456, 1'b1, 1'b0, 32'h0BEE_F803, 2'd0, 1'b1, 5, 0);
    translate(32'h0002_2222, 1'b0, 1'b1, 32'h0001_1807, 2'd0, 1'b1, 0, 4);
    translate(32'h0003_3333, 1'b1, 1'b1, 32'h0001_1805, 2'd3, 1'b0, 3, 3);

    // base near top of space: entry address wraps
    pt_base = 32'hFFFF_FFF0;
    translate(32'h0000_8ABC, 1'b0, 1'b0, 32'h0005_5823, 2'd0, 1'b0, 0, 0);
    pt_base = 32'h0040_0000;

    // reset in mid-walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_1000; req_write = 1'b0; req_user = 1'b0;
    cur_pte = 32'h0000_1807;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid && !mem_rsp_ready, "R11 mid-walk reset",
        {28'd0, req_ready, rsp_valid, mem_req_valid, mem_rsp_ready}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    translate(32'h0004_4000, 1'b0, 1'b1, 32'h0006_6807, 2'd0, 1'b1, 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule